// File: doc/BRIEF.md
# Scanout Base and Pitch Selector

This block tells a display fetch engine three things for the coming frame: how many bytes separate one scan line from the next, at which byte address the frame starts, and which pixel format the line drawer must use. Two register sources feed it. The first is the set of legacy CRTC registers, including vendor extension fields. The second is an extended linear-framebuffer register file. When the extended-mode enable is set, the extended values win outright. When it is clear, the pitch and start address are assembled from the legacy fields.

The colour depth from the extended register file is mapped to a compact format code. A flag is raised when that format reads through the palette. All outputs are registered. They reload only on a frame-start strobe, so software can rewrite registers mid-frame without tearing the picture. A one-cycle full-update pulse tells the fetch engine that the geometry or format it had cached is stale.

Top module: `scan_sel`

## Requirements
- R1: After reset, pitch_o and start_o are 0, fmt_o is 0, pal_needed_o is 1 and full_update_o is 0.
- R2: In legacy mode, pitch_o equals (crtc_offset_i + 256*h) * 8, where h is bits 5:4 of crtc_pitch_ext_i whenever that field is nonzero.
- R3: In legacy mode, when bits 5:4 of crtc_pitch_ext_i are zero, h equals bit 2 of crtc_misc_i. The top pitch bit is then 0.
- R4: In legacy mode, start_o equals {crtc_start_ext_i[4:0], crtc_start_hi_i, crtc_start_lo_i}, with all higher bits zero.
- R5: In extended mode (ext_en_i=1), pitch_o equals ext_pitch_i and start_o equals ext_start_i. The legacy fields have no effect.
- R6: In extended mode, ext_bpp_i selects fmt_o as follows: 8 gives 1, 15 gives 2, 16 gives 3, 24 gives 4 and 32 gives 5. Any other depth gives 1. pal_needed_o is 1 only for codes 0 and 1.
- R7: In legacy mode, fmt_o is 0 (pixel-doubled 8-bit) and pal_needed_o is 1, whatever ext_bpp_i holds.
- R8: Outputs take the values computed from the inputs sampled at a clock edge where frame_start_i is 1. They hold otherwise, so input changes between strobes have no effect on the outputs.
- R9: full_update_o is 1 for exactly the cycle after a frame-start edge that changed pitch_o, start_o or fmt_o. It is 0 after a frame start that changed none of them, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame boundary strobe; reloads the outputs |
| ext_en_i | input | 1 | Extended mode enable |
| ext_pitch_i | input | PITCH_W | Extended line pitch in bytes |
| ext_start_i | input | ADDR_W | Extended start byte address |
| ext_bpp_i | input | 8 | Extended colour depth in bits per pixel |
| crtc_offset_i | input | 8 | Legacy row offset, low pitch byte |
| crtc_pitch_ext_i | input | 8 | Legacy extension register; bits 5:4 give pitch bits 9:8 |
| crtc_misc_i | input | 8 | Legacy extension register; bit 2 is the fallback pitch bit 8 |
| crtc_start_lo_i | input | 8 | Legacy start address bits 7:0 |
| crtc_start_hi_i | input | 8 | Legacy start address bits 15:8 |
| crtc_start_ext_i | input | 8 | Legacy extension; bits 4:0 give start bits 20:16 |
| pitch_o | output | PITCH_W | Registered line pitch in bytes |
| start_o | output | ADDR_W | Registered start byte address |
| fmt_o | output | 3 | Registered line-draw format code |
| pal_needed_o | output | 1 | Registered flag: format reads through the palette |
| full_update_o | output | 1 | One-cycle pulse when pitch, start or format changed |

## Verification
The bench targets the fallback for the legacy pitch high bits. It uses cases where the primary extension field is zero with the fallback bit both set and clear. A design that ignored the fallback, or that ORed the two sources, would give a pitch off by 2048 bytes. It drives every listed depth plus 4 and 0. A missing default would leave a stale or illegal format code. It also writes garbage into the legacy fields while extended mode is on, to catch a mux that leaks them. The bench changes inputs between strobes and repeats an identical frame. A design without the frame latch would tear, and a free-running change detector would raise full_update_o when nothing moved.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;
  typedef enum logic [2:0] {
    FMT_8_DBL = 3'd0,
    FMT_8     = 3'd1,
    FMT_15    = 3'd2,
    FMT_16    = 3'd3,
    FMT_24    = 3'd4,
    FMT_32    = 3'd5
  } fmt_e;

  localparam int unsigned LEG_PITCH_W = 13;  // 10-bit word count << 3
  localparam int unsigned LEG_ADDR_W  = 21;
endpackage

// File: rtl/scan_legacy_calc.sv
module scan_legacy_calc
  import scan_sel_pkg::*;
#(
  parameter int unsigned PITCH_W = 16,
  parameter int unsigned ADDR_W  = 24
) (
  input  logic [7:0]         offset_i,
  input  logic [7:0]         pitch_ext_i,
  input  logic [7:0]         misc_i,
  input  logic [7:0]         start_lo_i,
  input  logic [7:0]         start_hi_i,
  input  logic [7:0]         start_ext_i,
  output logic [PITCH_W-1:0] pitch_o,
  output logic [ADDR_W-1:0]  start_o
);
  logic [1:0] hi_bits;
  logic       unused_bits;

  assign unused_bits = ^{pitch_ext_i[7:6], pitch_ext_i[3:0], misc_i[7:3], misc_i[1:0],
                         start_ext_i[7:5]};

  // primary extension field, falling back to the single misc bit
  always_comb begin
    if (pitch_ext_i[5:4] != 2'b00) hi_bits = pitch_ext_i[5:4];
    else                           hi_bits = {1'b0, misc_i[2]};
  end

  always_comb begin
    pitch_o = '0;
    pitch_o[LEG_PITCH_W-1:0] = {hi_bits, offset_i, 3'b000};
    start_o = '0;
    start_o[LEG_ADDR_W-1:0] = {start_ext_i[4:0], start_hi_i, start_lo_i};
  end
endmodule

// File: rtl/scan_fmt_decode.sv
module scan_fmt_decode
  import scan_sel_pkg::*;
#(
  parameter int unsigned BPP_W = 8
) (
  input  logic             ext_en_i,
  input  logic [BPP_W-1:0] bpp_i,
  output fmt_e             fmt_o,
  output logic             pal_o
);
  always_comb begin
    if (!ext_en_i) begin
      fmt_o = FMT_8_DBL;
    end else begin
      case (bpp_i)
        BPP_W'(15): fmt_o = FMT_15;
        BPP_W'(16): fmt_o = FMT_16;
        BPP_W'(24): fmt_o = FMT_24;
        BPP_W'(32): fmt_o = FMT_32;
        default:    fmt_o = FMT_8;
      endcase
    end
    pal_o = (fmt_o == FMT_8_DBL) || (fmt_o == FMT_8);
  end
endmodule

// File: rtl/scan_sel.sv
module scan_sel
  import scan_sel_pkg::*;
#(
  parameter int unsigned PITCH_W = 16,
  parameter int unsigned ADDR_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               ext_en_i,
  input  logic [PITCH_W-1:0] ext_pitch_i,
  input  logic [ADDR_W-1:0]  ext_start_i,
  input  logic [7:0]         ext_bpp_i,
  input  logic [7:0]         crtc_offset_i,
  input  logic [7:0]         crtc_pitch_ext_i,
  input  logic [7:0]         crtc_misc_i,
  input  logic [7:0]         crtc_start_lo_i,
  input  logic [7:0]         crtc_start_hi_i,
  input  logic [7:0]         crtc_start_ext_i,
  output logic [PITCH_W-1:0] pitch_o,
  output logic [ADDR_W-1:0]  start_o,
  output logic [2:0]         fmt_o,
  output logic               pal_needed_o,
  output logic               full_update_o
);
  logic [PITCH_W-1:0] leg_pitch, nxt_pitch, pitch_q;
  logic [ADDR_W-1:0]  leg_start, nxt_start, start_q;
  fmt_e               nxt_fmt, fmt_q;
  logic               nxt_pal, pal_q, upd_q, changed;

  scan_legacy_calc #(.PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_legacy (
    .offset_i    (crtc_offset_i),
    .pitch_ext_i (crtc_pitch_ext_i),
    .misc_i      (crtc_misc_i),
    .start_lo_i  (crtc_start_lo_i),
    .start_hi_i  (crtc_start_hi_i),
    .start_ext_i (crtc_start_ext_i),
    .pitch_o     (leg_pitch),
    .start_o     (leg_start)
  );

  scan_fmt_decode #(.BPP_W(8)) u_fmt (
    .ext_en_i (ext_en_i),
    .bpp_i    (ext_bpp_i),
    .fmt_o    (nxt_fmt),
    .pal_o    (nxt_pal)
  );

  assign nxt_pitch = ext_en_i ? ext_pitch_i : leg_pitch;
  assign nxt_start = ext_en_i ? ext_start_i : leg_start;
  assign changed   = (nxt_pitch != pitch_q) || (nxt_start != start_q) || (nxt_fmt != fmt_q);

  // shadow registers reload only at the frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pitch_q <= '0;
      start_q <= '0;
      fmt_q   <= FMT_8_DBL;
      pal_q   <= 1'b1;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= frame_start_i && changed;
      if (frame_start_i) begin
        pitch_q <= nxt_pitch;
        start_q <= nxt_start;
        fmt_q   <= nxt_fmt;
        pal_q   <= nxt_pal;
      end
    end
  end

  assign pitch_o       = pitch_q;
  assign start_o       = start_q;
  assign fmt_o         = fmt_q;
  assign pal_needed_o  = pal_q;
  assign full_update_o = upd_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable({pitch_q, start_q, fmt_q, pal_q}));

  p_upd_after_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_update_o |-> $past(frame_start_i));

  p_change_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({pitch_q, start_q, fmt_q}) |-> full_update_o);

  p_legacy_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !ext_en_i) |=> (pitch_o[2:0] == 3'b000));

  p_legacy_fmt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !ext_en_i) |=> (pal_needed_o && fmt_o == 3'd0));

  p_ext_pitch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && ext_en_i) |=> (pitch_o == $past(ext_pitch_i)));
endmodule

// File: tb/scan_sel_test.sv
module scan_sel_test;
  localparam int CLK_NS  = 10;
  localparam int PITCH_W = 16;
  localparam int ADDR_W  = 24;

  typedef struct {
    int unsigned pitch;
    int unsigned start;
    int unsigned fmt;
    int unsigned pal;
    int unsigned upd;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, ext_en = 1'b0;
  logic [PITCH_W-1:0] ext_pitch = '0;
  logic [ADDR_W-1:0]  ext_start = '0;
  logic [7:0] ext_bpp = 8'd0, c_off = 8'd0, c_pext = 8'd0, c_misc = 8'd0;
  logic [7:0] c_slo = 8'd0, c_shi = 8'd0, c_sext = 8'd0;
  logic [PITCH_W-1:0] pitch_o;
  logic [ADDR_W-1:0]  start_o;
  logic [2:0] fmt_o;
  logic pal_o, upd_o, fs_seen = 1'b0;

  int compared = 0, mismatched = 0;
  exp_t q[$];
  exp_t last = '{0, 0, 0, 1, 0, "R1"};

  always #(CLK_NS/2) clk = ~clk;

  scan_sel #(.PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .ext_en_i(ext_en),
    .ext_pitch_i(ext_pitch), .ext_start_i(ext_start), .ext_bpp_i(ext_bpp),
    .crtc_offset_i(c_off), .crtc_pitch_ext_i(c_pext), .crtc_misc_i(c_misc),
    .crtc_start_lo_i(c_slo), .crtc_start_hi_i(c_shi), .crtc_start_ext_i(c_sext),
    .pitch_o(pitch_o), .start_o(start_o), .fmt_o(fmt_o), .pal_needed_o(pal_o),
    .full_update_o(upd_o)
  );

  task automatic chk(string tag, string what, int unsigned got, int unsigned exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  function automatic exp_t model(string tag);
    exp_t e;
    int unsigned h;
    e.tag = tag;
    if (ext_en) begin
      e.pitch = ext_pitch;                    // R5
      e.start = ext_start;
      case (ext_bpp)                          // R6
        8'd15: e.fmt = 2;
        8'd16: e.fmt = 3;
        8'd24: e.fmt = 4;
        8'd32: e.fmt = 5;
        default: e.fmt = 1;
      endcase
    end else begin
      h = (c_pext >> 4) & 3;                  // R2
      if (h == 0) h = (c_misc >> 2) & 1;      // R3
      e.pitch = (c_off + 256 * h) * 8;
      e.start = ((c_sext & 32'h1f) << 16) | (c_shi << 8) | c_slo;  // R4
      e.fmt = 0;                              // R7
    end
    e.pal = (e.fmt <= 1) ? 1 : 0;
    e.upd = (e.pitch != last.pitch || e.start != last.start || e.fmt != last.fmt) ? 1 : 0;  // R9
    last = e;
    return e;
  endfunction

  task automatic run_frame(string tag);
    @(negedge clk);
    frame_start = 1'b1;
    q.push_back(model(tag));
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // monitor
  exp_t cur = '{0, 0, 0, 1, 0, "R1"};
  always @(posedge clk) fs_seen <= frame_start;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fs_seen && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cur = e;
        chk(e.tag, "pitch", pitch_o, e.pitch);
        chk(e.tag, "start", start_o, e.start);
        chk(e.tag, "fmt", fmt_o, e.fmt);
        chk(e.tag, "pal", pal_o, e.pal);
        chk({e.tag, "/R9"}, "full_update", upd_o, e.upd);
      end else begin
        chk("R8", "held pitch", pitch_o, cur.pitch);
        chk("R8", "held start", start_o, cur.start);
        chk("R8", "held fmt", fmt_o, cur.fmt);
        chk("R9", "idle full_update", upd_o, 0);
      end
    end
  end

  task automatic scribble();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      c_off = c_off + 8'h11; c_pext = c_pext ^ 8'h30; c_slo = c_slo + 8'h05;
      ext_pitch = ext_pitch + 16'h0040; ext_bpp = ext_bpp ^ 8'h08; ext_en = ~ext_en;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_NS * 3 + 2);
    // R1: reset state, checked while reset is still asserted and after release
    chk("R1", "pitch", pitch_o, 0);
    chk("R1", "start", start_o, 0);
    chk("R1", "fmt", fmt_o, 0);
    chk("R1", "pal", pal_o, 1);
    chk("R1", "full_update", upd_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 primary field; R4 start
    c_off = 8'h50; c_pext = 8'h20; c_misc = 8'h04;
    c_slo = 8'h34; c_shi = 8'h12; c_sext = 8'hFF; ext_bpp = 8'd32;
    run_frame("R2");
    // R3 fallback bit set
    c_off = 8'h10; c_pext = 8'hCF; c_misc = 8'h04; c_sext = 8'h05;
    run_frame("R3");
    // R3 fallback bit clear
    c_misc = 8'hFB;
    run_frame("R3");
    // R9 identical frame: no update
    run_frame("R9");
    // R8 mid-frame scribbles must not reach the outputs
    scribble();
    // restore to known values then extended mode
    ext_en = 1'b1; ext_pitch = 16'h0A00; ext_start = 24'h123456; ext_bpp = 8'd8;
    c_off = 8'hAA; c_pext = 8'h30; c_misc = 8'hFF; c_slo = 8'h99; c_shi = 8'h88; c_sext = 8'h1F;
    run_frame("R5");
    ext_bpp = 8'd15; run_frame("R6");
    ext_bpp = 8'd16; run_frame("R6");
    ext_bpp = 8'd24; run_frame("R6");
    ext_bpp = 8'd32; run_frame("R6");
    ext_bpp = 8'd4;  run_frame("R6");
    ext_bpp = 8'd32; run_frame("R6");
    ext_bpp = 8'd0;  run_frame("R6");
    // R5: legacy fields changed, extended result unchanged
    c_off = 8'h01; c_slo = 8'h02; run_frame("R5");
    // back-to-back strobes
    ext_pitch = 16'h1F40; ext_start = 24'hABCDE0;
    @(negedge clk); frame_start = 1'b1; q.push_back(model("R8"));
    @(negedge clk); ext_en = 1'b0; ext_bpp = 8'd24; q.push_back(model("R7"));
    @(negedge clk); frame_start = 1'b0;
    scribble();
    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R8 queue: got %0d pending expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule